// File: doc/BRIEF.md
# Sender handshake port with clock-stretch

This block is the outgoing data port of a locally clocked module. When the local module pulses its write strobe, the port captures the data word and raises a stretch request that holds the local clock in its low phase. On the next cycle it raises the request line and then waits for a passive receiver to acknowledge. The port is always the active party: the receiver never starts an exchange. The exchange is a four-phase, bundled-data handshake.

Once the acknowledge is seen, the request and the stretch request fall on the same edge, so the local clock resumes without waiting for the acknowledge to return low. A new transfer starts only after the acknowledge is seen low again. A strobe that arrives while the port is busy is parked in a single-entry slot and sent next. The whole port is modelled as a synchronous state machine on a fast reference clock. The acknowledge, which comes from another clock region, passes through a synchronizer of `SYNC_STAGES` flops first.

Top module: `hs_send_port`

## Requirements
- R1: While reset is asserted, `req_out` and `stretch_out` are low and `bus_data` is zero.
- R2: When the port is idle and `wr_strobe` is high at a clock edge after being low at the previous edge, `stretch_out` is high after that edge and `req_out` is still low.
- R3: `req_out` rises on the edge after `stretch_out` rises, and `req_out` is never high while `stretch_out` is low.
- R4: `bus_data` shows the word that was on `wr_data` in the strobe cycle that started the transfer, and it does not change while `req_out` is high.
- R5: After `ack_in` rises, `req_out` stays high for `SYNC_STAGES` edges and falls on edge number `SYNC_STAGES`+1.
- R6: `stretch_out` falls on the same edge as `req_out`, while `ack_in` is still high.
- R7: The strobe acts on its rising edge only: a strobe held high for any length of time yields exactly one transfer.
- R8: A strobe rise while a transfer is in progress is parked with its data and is sent as the next transfer. Only one strobe can be parked; further rises while the slot is full are dropped.
- R9: After `ack_in` falls, no new `stretch_out` rises for `SYNC_STAGES` edges. A parked transfer, or a strobe rise in the cycle when the acknowledge low is first seen, raises `stretch_out` on edge `SYNC_STAGES`+1. When both are present, the parked one goes first and the new strobe is parked in its place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock that samples all state |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_strobe | input | 1 | Write strobe from the local module, acts on its rising edge |
| wr_data | input | W | Word to send, sampled in the strobe cycle |
| ack_in | input | 1 | Acknowledge from the receiver, asynchronous |
| req_out | output | 1 | Request toward the receiver |
| stretch_out | output | 1 | Stretch request that holds the local clock low |
| bus_data | output | W | Data held stable for the receiver |

## Verification
The case of interest is a new strobe rise that lands in the very cycle in which the synchronized acknowledge is first seen low. In that cycle the port both releases the old handshake and starts a new one. The receiver model provokes this by raising the strobe `SYNC_STAGES` cycles after it drops the acknowledge. It then checks three things: `stretch_out` rises on exactly the next edge, no earlier; the transfer carries the new word; and no further transfer follows. A second case parks a strobe during a busy transfer and fires a third strobe that must be dropped. The scoreboard order shows whether the parked word went out and the dropped one did not.

// File: rtl/hs_send_pkg.sv
package hs_send_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_STRETCH = 2'd1,
        ST_REQ     = 2'd2,
        ST_WAIT    = 2'd3
    } hs_state_e;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            logic s_q;
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) s_q <= 1'b0;
                    else        s_q <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) s_q <= 1'b0;
                    else        s_q <= g_stage[i-1].s_q;
                end
            end
        end
    endgenerate

    assign q = g_stage[STAGES-1].s_q;
endmodule

// File: rtl/hs_rise_det.sv
module hs_rise_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    logic level_d, level_q;

    always_comb level_d = level;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level_d;
    end

    assign rise = level & ~level_q;
endmodule

// File: rtl/hs_send_fsm.sv
module hs_send_fsm
    import hs_send_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] start_data,
    input  logic         ack_seen,
    output logic         req,
    output logic         stretch,
    output logic [W-1:0] data
);
    typedef struct packed {
        hs_state_e    st;
        logic         req;
        logic         stretch;
        logic [W-1:0] data;
        logic         pend;
        logic [W-1:0] pend_data;
    } fsm_t;

    fsm_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st      = ST_STRETCH;
                    r_d.stretch = 1'b1;
                    r_d.data    = start_data;
                end
            end
            ST_STRETCH: begin
                r_d.st  = ST_REQ;
                r_d.req = 1'b1;
                if (start && !r_q.pend) begin
                    r_d.pend      = 1'b1;
                    r_d.pend_data = start_data;
                end
            end
            ST_REQ: begin
                if (ack_seen) begin
                    r_d.st      = ST_WAIT;
                    r_d.req     = 1'b0;
                    r_d.stretch = 1'b0;
                end
                if (start && !r_q.pend) begin
                    r_d.pend      = 1'b1;
                    r_d.pend_data = start_data;
                end
            end
            ST_WAIT: begin
                if (!ack_seen) begin
                    if (r_q.pend) begin
                        r_d.st      = ST_STRETCH;
                        r_d.stretch = 1'b1;
                        r_d.data    = r_q.pend_data;
                        r_d.pend    = start;
                        if (start) r_d.pend_data = start_data;
                    end else if (start) begin
                        r_d.st      = ST_STRETCH;
                        r_d.stretch = 1'b1;
                        r_d.data    = start_data;
                    end else begin
                        r_d.st = ST_IDLE;
                    end
                end else if (start && !r_q.pend) begin
                    r_d.pend      = 1'b1;
                    r_d.pend_data = start_data;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st        <= ST_IDLE;
            r_q.req       <= 1'b0;
            r_q.stretch   <= 1'b0;
            r_q.data      <= '0;
            r_q.pend      <= 1'b0;
            r_q.pend_data <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req     = r_q.req;
    assign stretch = r_q.stretch;
    assign data    = r_q.data;
endmodule

// File: rtl/hs_send_port.sv
module hs_send_port #(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_strobe,
    input  logic [W-1:0] wr_data,
    input  logic         ack_in,
    output logic         req_out,
    output logic         stretch_out,
    output logic [W-1:0] bus_data
);
    logic strobe_rise;
    logic ack_seen;

    hs_rise_det u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .level (wr_strobe),
        .rise  (strobe_rise)
    );

    hs_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ack_in),
        .q     (ack_seen)
    );

    hs_send_fsm #(.W(W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (strobe_rise),
        .start_data (wr_data),
        .ack_seen   (ack_seen),
        .req        (req_out),
        .stretch    (stretch_out),
        .data       (bus_data)
    );
endmodule

// File: rtl/hs_send_port_chk.sv
module hs_send_port_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ack_in,
    input logic         req_out,
    input logic         stretch_out,
    input logic [W-1:0] bus_data
);
    AST_STRETCH_BEFORE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_out) |-> $past(stretch_out)); // R3

    AST_REQ_UNDER_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
        req_out |-> stretch_out); // R3

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_out && $past(req_out)) |-> $stable(bus_data)); // R4

    AST_REQ_DROP_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_out) |-> $past(ack_in)); // R5

    AST_STRETCH_DROP_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_out) |-> $fell(stretch_out)); // R6

    AST_NO_START_UNDER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stretch_out) |-> !ack_in); // R9
endmodule

bind hs_send_port hs_send_port_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_in      (ack_in),
    .req_out     (req_out),
    .stretch_out (stretch_out),
    .bus_data    (bus_data)
);

// File: tb/hs_send_port_test.sv
module hs_send_port_test;
    localparam int W    = 8;
    localparam int SYNC = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_strobe = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         ack_in = 1'b0;
    logic         req_out;
    logic         stretch_out;
    logic [W-1:0] bus_data;

    int tests = 0;
    int fails = 0;
    int xfers = 0;
    int ack_delay = 1;
    int ack_hold = 2;
    bit same_flag = 1'b0;
    logic [W-1:0] same_data = '0;
    logic [W-1:0] exp_q[$];

    always #2 clk = ~clk;

    hs_send_port #(.W(W), .SYNC_STAGES(SYNC)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_strobe   (wr_strobe),
        .wr_data     (wr_data),
        .ack_in      (ack_in),
        .req_out     (req_out),
        .stretch_out (stretch_out),
        .bus_data    (bus_data)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // receiver model and scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && req_out) begin
                logic [W-1:0] exp;
                bit pend;
                xfers++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected transfer", bus_data, -1);
                    exp = bus_data;
                end else begin
                    exp = exp_q.pop_front();
                end
                check(bus_data == exp, "R4 data", bus_data, exp);
                check(stretch_out == 1'b1, "R3 stretch with req", stretch_out, 1);
                for (int i = 0; i < ack_delay; i++) begin
                    @(negedge clk);
                    check(bus_data == exp && req_out, "R4 data held", bus_data, exp);
                end
                ack_in = 1'b1;
                for (int k = 1; k <= SYNC + 1; k++) begin
                    @(negedge clk);
                    if (k <= SYNC) check(req_out == 1'b1, "R5 req held", req_out, 1);
                    else begin
                        check(req_out == 1'b0, "R5 req drop", req_out, 0);
                        check(stretch_out == 1'b0, "R6 stretch drop", stretch_out, 0);
                    end
                end
                for (int i = 0; i < ack_hold; i++) @(negedge clk);
                check(stretch_out == 1'b0 && req_out == 1'b0, "R6 released under ack", stretch_out, 0);
                ack_in = 1'b0;
                pend = (exp_q.size() > 0) || same_flag;
                for (int k = 1; k <= SYNC + 1; k++) begin
                    @(negedge clk);
                    if (k <= SYNC) check(stretch_out == 1'b0, "R9 no early start", stretch_out, 0);
                    else if (pend) check(stretch_out == 1'b1, "R9 start on ack low", stretch_out, 1);
                    if (k == SYNC && same_flag) begin
                        wr_strobe = 1'b1;
                        wr_data   = same_data;
                        exp_q.push_back(same_data);
                        same_flag = 1'b0;
                    end else if (k == SYNC + 1) begin
                        wr_strobe = 1'b0;
                    end
                end
            end
        end
    end

    task automatic send_idle(input logic [W-1:0] d);
        @(negedge clk);
        wr_strobe = 1'b1;
        wr_data   = d;
        exp_q.push_back(d);
        @(negedge clk);
        check(stretch_out == 1'b1, "R2 stretch first", stretch_out, 1);
        check(req_out == 1'b0, "R2 req not yet", req_out, 0);
        wr_strobe = 1'b0;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        while (quiet < 12) begin
            @(negedge clk);
            if (!req_out && !stretch_out && !ack_in && exp_q.size() == 0 && !same_flag) quiet++;
            else quiet = 0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int base;
        repeat (4) @(negedge clk);
        check(req_out == 1'b0 && stretch_out == 1'b0 && bus_data == '0, "R1 reset", {req_out, stretch_out}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // basic transfers, varied acknowledge latency
        ack_delay = 0; send_idle(8'hA5); wait_idle();
        ack_delay = 3; send_idle(8'h5A); wait_idle();
        ack_delay = 7; ack_hold = 5; send_idle(8'h0F); wait_idle();
        check(xfers == 3, "R4 transfer count", xfers, 3);

        // level strobe held long: one transfer only
        ack_delay = 1; ack_hold = 2;
        base = xfers;
        @(negedge clk);
        wr_strobe = 1'b1;
        wr_data   = 8'h3C;
        exp_q.push_back(8'h3C);
        repeat (60) @(negedge clk);
        check(xfers - base == 1, "R7 held strobe", xfers - base, 1);
        wr_strobe = 1'b0;
        wait_idle();
        check(xfers - base == 1, "R7 after release", xfers - base, 1);

        // parked strobe plus one dropped strobe
        base = xfers;
        ack_delay = 4;
        send_idle(8'h11);
        while (!req_out) @(negedge clk);
        wr_strobe = 1'b1; wr_data = 8'h22; exp_q.push_back(8'h22);
        @(negedge clk); wr_strobe = 1'b0;
        @(negedge clk); wr_strobe = 1'b1; wr_data = 8'h33;
        @(negedge clk); wr_strobe = 1'b0; wr_data = 8'h00;
        wait_idle();
        check(xfers - base == 2, "R8 parked and dropped", xfers - base, 2);
        check(bus_data == 8'h22, "R8 last word", bus_data, 8'h22);

        // strobe in the cycle ack low is first seen
        base = xfers;
        ack_delay = 1;
        same_data = 8'h55;
        send_idle(8'h44);
        same_flag = 1'b1;
        wait_idle();
        check(xfers - base == 2, "R9 same-cycle restart", xfers - base, 2);
        check(bus_data == 8'h55, "R9 same-cycle word", bus_data, 8'h55);

        check(exp_q.size() == 0, "R8 scoreboard empty", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule